// File: doc/BRIEF.md
# HDLC Frame Transmitter with Automatic Underrun Abort

This block turns a stream of host bytes into a bit-serial HDLC line, one bit per clock. Bytes enter through a 64-entry transmit queue. Each entry carries a ninth bit, the end-of-message mark. When no data is waiting, the line carries back-to-back flags. When a byte arrives, the current flag completes and acts as the opening flag. The data bytes then follow, least significant bit first, with zero-bit insertion. After the byte that carries the end-of-message mark, the block appends the 16-bit frame check sequence and a closing flag.

The queue can run dry in the middle of a frame, before the marked byte has been queued. The block treats this as an underrun and ends the frame by itself with an abort pattern, then returns to idle flags. The underrun is recorded in a sticky event bit that the host clears with a read strobe. Real-time full and empty flags let the host pace its writes.

The host write port is valid/ready. A byte is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while the queue is full. The host may hold `wr_valid` high for as long as it wants, and the byte presented while `wr_ready` is low is not stored. The line output has no back-pressure: a new bit appears every clock.

Top module: `hdlc_tx_abort`

## Requirements
- R1: With the queue empty and no frame in progress, the line repeats the flag 0x7E, sent LSB first, without a break. Every frame is preceded by at least one complete flag.
- R2: The bytes of a message appear between the flags in the order they were written, each sent least significant bit first.
- R3: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1 in reflected form (0x8408), preset to 0xFFFF and computed over the data bits. It is sent complemented, low byte first, least significant bit first.
- R4: A 0 is inserted after every run of five 1s inside the data and check-sequence fields. No insertion is made inside flags or the abort pattern.
- R5: After the last bit of the byte whose end-of-message mark (bit 8 of the entry, `wr_last`) is set, the check sequence and then one closing flag are sent.
- R6: If the queue is empty when the next byte of a frame is needed and the end-of-message mark has not been seen, the frame ends with an abort of eight 1 bits, followed by idle flags.
- R7: `underrun_evt` goes high after an underrun and stays high until a cycle in which `evt_rd` is high clears it. A frame that completes normally does not set it.
- R8: If `evt_rd` is high in the same cycle as a new underrun, `underrun_evt` is set after that edge.
- R9: A byte is stored only on an edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low while the queue is full, and bytes presented then are dropped.
- R10: `fifo_full` is high exactly while 64 entries are held, and `fifo_empty` is high exactly while none are held.
- R11: While `rst_n` is low, `tx_bit` is 1, `fifo_empty` is 1, `fifo_full` is 0, `wr_ready` is 1 and `underrun_evt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host presents a byte |
| wr_ready | output | 1 | Queue can take a byte this cycle |
| wr_data | input | 8 | Byte to transmit |
| wr_last | input | 1 | End-of-message mark for this byte |
| tx_bit | output | 1 | Serial line output |
| fifo_full | output | 1 | Queue holds 64 entries |
| fifo_empty | output | 1 | Queue holds no entries |
| evt_rd | input | 1 | Event read strobe, clears the underrun event |
| underrun_evt | output | 1 | Sticky underrun event |

## Verification
The hardest condition to reach is an event read that lands on the very edge where a new underrun is detected. The exact cycle depends on where the flag boundary fell and on how many stuffed zeros the data produced. The stimulus does not try to predict that cycle. It holds `evt_rd` high through the whole frame and lets the queue starve, so the read is present on the colliding edge by construction. The event must then be seen high for at least one cycle before the continuing read clears it. Full-queue behaviour is reached by offering bytes on every cycle, since the line drains only one byte per eight or nine cycles.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CRC   = 2'd2,
    ST_ABORT = 2'd3
  } tx_state_e;

  localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE   = 8'hFF;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_INIT     = 16'hFFFF;
  localparam logic [2:0]  STUFF_RUN    = 3'd5;

  // one bit of the reflected CRC-16 shift
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {1'b0, c[15:1]} ^ (fb ? CRC_POLY_REV : 16'h0000);
  endfunction

  function automatic logic stuffable(input tx_state_e s);
    return (s == ST_DATA) || (s == ST_CRC);
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  a_r10_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r9_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/hdlc_tx_event.sv
module hdlc_tx_event (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic evt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     evt_o <= 1'b0;
    else if (set_i) evt_o <= 1'b1;
    else if (clr_i) evt_o <= 1'b0;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> evt_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !clr_i) |=> evt_o);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !evt_o);

endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_empty,
  input  logic [7:0] q_data,
  input  logic       q_last,
  output logic       q_pop,
  output logic       uflow,
  output logic       tx_bit
);
  tx_state_e   st, n_st, u_st;
  logic [15:0] sh, n_sh, u_sh;
  logic [4:0]  left, n_left, u_left;
  logic [2:0]  ones, n_ones;
  logic [15:0] crc, n_crc, crc_base;
  logic        last_q, n_last, n_bit;

  always_comb begin
    n_st = st; n_sh = sh; n_left = left; n_ones = ones;
    n_crc = crc; n_last = last_q; n_bit = tx_bit;
    u_st = st; u_sh = sh; u_left = left; crc_base = crc;
    q_pop = 1'b0; uflow = 1'b0;
    if (stuffable(st) && ones == STUFF_RUN) begin
      n_bit  = 1'b0;
      n_ones = '0;
    end else begin
      if (left == '0) begin
        case (st)
          ST_FLAG: begin
            if (!q_empty) begin
              u_st = ST_DATA; u_sh = {8'h00, q_data}; u_left = 5'd8;
              q_pop = 1'b1; n_last = q_last; crc_base = CRC_INIT;
            end else begin
              u_st = ST_FLAG; u_sh = {8'h00, FLAG_BYTE}; u_left = 5'd8;
            end
          end
          ST_DATA: begin
            if (last_q) begin
              u_st = ST_CRC; u_sh = ~crc; u_left = 5'd16;
            end else if (!q_empty) begin
              u_st = ST_DATA; u_sh = {8'h00, q_data}; u_left = 5'd8;
              q_pop = 1'b1; n_last = q_last;
            end else begin
              u_st = ST_ABORT; u_sh = {8'h00, ABORT_BYTE}; u_left = 5'd8;
              uflow = 1'b1;
            end
          end
          default: begin
            u_st = ST_FLAG; u_sh = {8'h00, FLAG_BYTE}; u_left = 5'd8;
          end
        endcase
      end
      n_bit  = u_sh[0];
      n_sh   = {1'b0, u_sh[15:1]};
      n_left = u_left - 5'd1;
      n_st   = u_st;
      if (stuffable(u_st)) n_ones = u_sh[0] ? 3'(ones + 3'd1) : '0;
      else                 n_ones = '0;
      if (u_st == ST_DATA) n_crc = crc_step(crc_base, u_sh[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_FLAG; sh <= '0; left <= '0; ones <= '0;
      crc <= CRC_INIT; last_q <= 1'b0; tx_bit <= 1'b1;
    end else begin
      st <= n_st; sh <= n_sh; left <= n_left; ones <= n_ones;
      crc <= n_crc; last_q <= n_last; tx_bit <= n_bit;
    end
  end

  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stuffable(st) |-> ones <= STUFF_RUN);
  a_r6_abort_first_one: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> tx_bit);
  a_r6_abort_enters: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> st == ST_ABORT);
  a_r6_no_pop_empty_q: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> !q_empty);

endmodule

// File: rtl/hdlc_tx_abort.sv
module hdlc_tx_abort #(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  output logic       tx_bit,
  output logic       fifo_full,
  output logic       fifo_empty,
  input  logic       evt_rd,
  output logic       underrun_evt
);
  localparam int EW = 9;

  logic          push, pop, uflow;
  logic [EW-1:0] head;

  assign wr_ready = !fifo_full;
  assign push     = wr_valid && wr_ready;

  hdlc_tx_fifo #(.DEPTH(DEPTH), .WIDTH(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data({wr_last, wr_data}),
    .pop(pop), .head(head), .full(fifo_full), .empty(fifo_empty)
  );

  hdlc_tx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .q_empty(fifo_empty), .q_data(head[7:0]),
    .q_last(head[8]), .q_pop(pop), .uflow(uflow), .tx_bit(tx_bit)
  );

  hdlc_tx_event u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(uflow), .clr_i(evt_rd), .evt_o(underrun_evt)
  );

  a_r9_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push);

endmodule

// File: tb/sim_hdlc_tx_abort.sv
module sim_hdlc_tx_abort;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_last = 1'b0, evt_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, tx_bit, fifo_full, fifo_empty, underrun_evt;

  int errors = 0, checks = 0, cyc = 0;

  hdlc_tx_abort u0 (.*);

  always #4 clk = ~clk;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference CRC-16, reflected 0x8408, preset all ones
  function automatic logic [15:0] ref_crc(input logic [7:0] m[$], input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {8'h00, m[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  // line decoder
  logic rxbits[$];
  logic [7:0] got[$];
  int ones_r = 0, n_frames = 0, n_aborts = 0, n_flags = 0, n_bad = 0;
  bit hunt = 1'b1, last_crc_ok = 1'b0;

  task automatic frame_done();
    logic [15:0] c;
    int nb;
    if (rxbits.size() % 8 != 0 || rxbits.size() < 24) begin
      n_bad++;
      return;
    end
    got.delete();
    nb = rxbits.size() / 8;
    for (int i = 0; i < nb; i++) begin
      logic [7:0] v = '0;
      for (int k = 0; k < 8; k++) v[k] = rxbits[i*8+k];
      got.push_back(v);
    end
    c = ~ref_crc(got, nb - 2);
    last_crc_ok = (got[nb-2] == c[7:0]) && (got[nb-1] == c[15:8]);
    void'(got.pop_back());
    void'(got.pop_back());
    n_frames++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_bit) begin
        ones_r++;
        if (!hunt) rxbits.push_back(1'b1);
        if (ones_r == 7) begin
          n_aborts++;
          hunt = 1'b1;
          rxbits.delete();
        end
      end else begin
        if (ones_r == 6) begin
          n_flags++;
          if (!hunt) begin
            repeat (7) if (rxbits.size() > 0) void'(rxbits.pop_back());
            if (rxbits.size() > 0) frame_done();
          end
          rxbits.delete();
          hunt = 1'b0;
        end else if (ones_r != 5 && !hunt) begin
          rxbits.push_back(1'b0);
        end
        ones_r = 0;
      end
    end
  end

  // host side, called at a negedge
  task automatic send(input logic [7:0] d, input logic l);
    bit acc;
    wr_valid = 1'b1; wr_data = d; wr_last = l;
    do begin acc = wr_ready; @(negedge clk); end while (!acc);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic try_send(input logic [7:0] d, output bit acc);
    wr_valid = 1'b1; wr_data = d; wr_last = 1'b0;
    acc = wr_ready;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_frame(input int f0, input int limit);
    for (int i = 0; i < limit && n_frames == f0; i++) @(negedge clk);
  endtask

  task automatic run_msg(input logic [7:0] m[$], input string tag);
    int f0 = n_frames, a0 = n_aborts;
    for (int i = 0; i < m.size(); i++) send(m[i], i == m.size() - 1);
    wait_frame(f0, m.size() * 30 + 200);
    chk({tag, " R5 frame closed"}, n_frames - f0, 1);
    chk({tag, " R2 length"}, got.size(), m.size());
    for (int i = 0; i < m.size() && i < got.size(); i++)
      chk({tag, " R2 byte"}, got[i], m[i]);
    chk({tag, " R3 check sequence"}, last_crc_ok, 1);
    chk({tag, " R4 no stray abort"}, n_aborts - a0, 0);
  endtask

  initial begin
    logic [7:0] m[$];
    int f0, a0, fl0;
    bit acc, seen_full, seen_drop, seen_evt;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    chk("R11 tx_bit", tx_bit, 1);
    chk("R11 fifo_empty", fifo_empty, 1);
    chk("R11 fifo_full", fifo_full, 0);
    chk("R11 wr_ready", wr_ready, 1);
    chk("R11 underrun_evt", underrun_evt, 0);
    rst_n = 1'b1;

    repeat (80) @(negedge clk);
    chk("R1 idle flags", int'(n_flags >= 8), 1);
    chk("R1 no frames idle", n_frames, 0);
    chk("R1 no aborts idle", n_aborts + n_bad, 0);

    // directed: long runs of ones need stuffing
    m = '{8'hFF, 8'h7E, 8'hFF, 8'h3E, 8'h1F};
    run_msg(m, "stuff");
    m = '{8'hA5};
    run_msg(m, "single");
    chk("R10 empty after frame", fifo_empty, 1);
    chk("R7 no event on good frames", underrun_evt, 0);

    // random messages
    for (int t = 0; t < 12; t++) begin
      int len = 1 + ($urandom % 24);
      m.delete();
      for (int i = 0; i < len; i++) m.push_back(8'($urandom));
      run_msg(m, "random");
    end

    // underrun: no end mark
    f0 = n_frames; a0 = n_aborts;
    send(8'h12, 1'b0);
    chk("R10 not empty after write", fifo_empty, 0);
    send(8'h34, 1'b0);
    send(8'h56, 1'b0);
    repeat (120) @(negedge clk);
    chk("R6 abort seen", n_aborts - a0, 1);
    chk("R6 no frame completed", n_frames - f0, 0);
    chk("R7 event set", underrun_evt, 1);
    fl0 = n_flags;
    repeat (60) @(negedge clk);
    chk("R6 idle flags after abort", int'(n_flags - fl0 >= 5), 1);
    chk("R7 event sticky", underrun_evt, 1);
    evt_rd = 1'b1;
    @(negedge clk);
    evt_rd = 1'b0;
    chk("R7 event cleared by read", underrun_evt, 0);
    m = '{8'h81, 8'hC3};
    run_msg(m, "after abort");

    // read held across a new underrun
    a0 = n_aborts; seen_evt = 1'b0;
    evt_rd = 1'b1;
    send(8'hF0, 1'b0);
    send(8'h0F, 1'b0);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (underrun_evt) seen_evt = 1'b1;
    end
    chk("R8 set beats read", seen_evt, 1);
    chk("R8 abort", n_aborts - a0, 1);
    chk("R8 cleared by held read", underrun_evt, 0);
    evt_rd = 1'b0;

    // fill the queue
    m.delete(); seen_full = 1'b0; seen_drop = 1'b0;
    f0 = n_frames;
    for (int i = 0; i < 110; i++) begin
      logic [7:0] d = 8'($urandom);
      if (fifo_full) begin
        seen_full = 1'b1;
        if (wr_ready) errors++;
      end
      try_send(d, acc);
      if (acc) m.push_back(d); else seen_drop = 1'b1;
    end
    chk("R10 full reached", seen_full, 1);
    chk("R9 bytes refused when full", seen_drop, 1);
    chk("R9 ready low when full", int'(fifo_full && wr_ready), 0);
    m.push_back(8'h5A);
    send(8'h5A, 1'b1);
    wait_frame(f0, 5000);
    chk("R9 frame length", got.size(), m.size());
    for (int i = 0; i < m.size() && i < got.size(); i++)
      chk("R9 kept bytes", got[i], m[i]);
    chk("R3 long frame check", last_crc_ok, 1);
    chk("R7 no event on full path", underrun_evt, 0);
    chk("R1 no malformed frames", n_bad, 0);

    summary();
    $finish;
  end
endmodule